// File: doc/BRIEF.md
# Interleaved Block Component Sequencer

This block produces the tag of each 8x8 block in an interleaved image scan, so that the decoder downstream can pick the right Huffman table set and quantization table for the block it is working on. The minimum coded unit (MCU) is made of one to four slots. Each slot names a component type. Each type repeats for a programmable number of consecutive blocks before the walk moves on to the next slot. After the last slot the walk returns to the first.

A 24-bit down-counter holds the number of blocks that remain. Three byte writes to one address load it. The same value is kept in a shadow copy, so that a restart-marker event can reload the counter and bring the walk back to the start of an MCU. When the counter reaches zero the block stops issuing tags and raises `done`. A block-done pulse moves the walk forward by one block.

Top module: `jseq_block_sequencer`

## Requirements
- R1: After reset, `done` is 1, `tag_valid` is 0 and `blocks_left` is 0.
- R2: Three writes to address 8 load the block counter, most significant byte first. The third write sets `blocks_left` to the assembled 24-bit value and moves the walk to slot 0, block 0.
- R3: A `blk_done` pulse while `tag_valid` is 1 lowers `blocks_left` by exactly one and moves the walk forward by one block.
- R4: `tag_type` is the type held for the current slot. The order register at address 1 holds slot k in bits [2k+1:2k].
- R5: Type t occurs in runs of the length held at address 4+t. A run length of zero acts as one.
- R6: The slot count is bits [1:0] of address 0 plus one. After the final block of the last slot, the walk returns to slot 0, block 0.
- R7: `tag_huff` is bit t of address 2, and `tag_qtab` is bits [2t+1:2t] of address 3, where t is the current type.
- R8: When bit 2 of address 0 is 1, `rst_mark` reloads `blocks_left` from the last loaded value and moves the walk to slot 0, block 0. In the same cycle it takes priority over `blk_done`.
- R9: When bit 2 of address 0 is 0, `rst_mark` has no effect on `blocks_left` or on the tag.
- R10: While `blocks_left` is 0, `tag_valid` is 0 and `done` is 1. A `blk_done` pulse then changes neither the count nor the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| blk_done | input | 1 | One-cycle pulse: the current block is finished |
| rst_mark | input | 1 | One-cycle pulse: a restart marker was found |
| tag_valid | output | 1 | A block tag is being issued |
| tag_type | output | 2 | Component type of the current block |
| tag_huff | output | 1 | Huffman table set for the current block |
| tag_qtab | output | 2 | Quantization table index for the current block |
| blocks_left | output | 24 | Blocks remaining in the counter |
| done | output | 1 | The counter has reached zero |

## Verification
Every result is due one clock edge after its cause. The edge that captures a third counter byte, a `blk_done` pulse or a `rst_mark` pulse also updates the registered slot, run and counter state, and the tag outputs are decoded from that state with no further register. The bench therefore drives each stimulus on a falling edge and holds it for one cycle. It compares the outputs at the next falling edge, after exactly one rising edge has passed. Corner cases are checked in the same way: the wrap after the last slot, a zero run length, a restart in the same cycle as a block-done pulse, and a block-done pulse at zero count.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
    localparam int TYPE_W  = 2;
    localparam int NTYPE   = 1 << TYPE_W;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 24;
    localparam int NBYTES  = CNT_W / BYTE_W;
    localparam int ADDR_W  = 4;
    localparam int RUN_W   = 8;

    localparam logic [ADDR_W-1:0] A_LAYOUT = 4'd0;
    localparam logic [ADDR_W-1:0] A_ORDER  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HUFF   = 4'd2;
    localparam logic [ADDR_W-1:0] A_QTAB   = 4'd3;
    localparam logic [ADDR_W-1:0] A_RUN0   = 4'd4;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd8;

    typedef logic [TYPE_W-1:0] ctype_t;

    typedef struct packed {
        logic                          rst_en;
        logic [TYPE_W-1:0]             last_slot;
        logic [NTYPE-1:0][TYPE_W-1:0]  order;
        logic [NTYPE-1:0]              huff;
        logic [NTYPE-1:0][1:0]         qtab;
        logic [NTYPE-1:0][RUN_W-1:0]   run;
    } cfg_t;

    typedef struct packed {
        logic       valid;
        ctype_t     ctype;
        logic       huff;
        logic [1:0] qtab;
    } tag_t;

    function automatic logic [RUN_W-1:0] final_run_idx(input logic [RUN_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction
endpackage

// File: rtl/jseq_regs.sv
module jseq_regs
    import jseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output cfg_t                cfg,
    output logic                load,
    output logic [CNT_W-1:0]    load_val
);
    localparam int PTR_W = $clog2(NBYTES);
    localparam int ACC_W = CNT_W - BYTE_W;

    logic [PTR_W-1:0] ptr;
    logic [ACC_W-1:0] acc;
    logic             cnt_wr;

    assign cnt_wr   = we && (addr == A_COUNT);
    assign load     = cnt_wr && (ptr == PTR_W'(NBYTES - 1));
    assign load_val = {acc, wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            ptr <= '0;
            acc <= '0;
        end else begin
            if (we) begin
                case (addr)
                    A_LAYOUT: begin
                        cfg.last_slot <= wdata[TYPE_W-1:0];
                        cfg.rst_en    <= wdata[TYPE_W];
                    end
                    A_ORDER: cfg.order <= wdata;
                    A_HUFF:  cfg.huff  <= wdata[NTYPE-1:0];
                    A_QTAB:  cfg.qtab  <= wdata;
                    default: ;
                endcase
                for (int t = 0; t < NTYPE; t++) begin
                    if (addr == A_RUN0 + ADDR_W'(t))
                        cfg.run[t] <= wdata;
                end
            end
            if (cnt_wr) begin
                acc <= {acc[ACC_W-BYTE_W-1:0], wdata};
                ptr <= load ? '0 : ptr + 1'b1;
            end
        end
    end

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(NBYTES - 1));
endmodule

// File: rtl/jseq_counter.sv
module jseq_counter
    import jseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    logic [CNT_W-1:0] shadow;

    assign zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            shadow <= '0;
        end else if (load) begin
            count  <= load_val;
            shadow <= load_val;
        end else if (reload) begin
            count  <= shadow;
        end else if (dec && !zero) begin
            count  <= count - 1'b1;
        end
    end

    // R3
    dec_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        dec && !zero && !load && !reload |=> count == $past(count) - 1'b1);

    // R10
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        zero && !load && !reload |=> zero);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        reload && !load |=> count == $past(shadow));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
endmodule

// File: rtl/jseq_walker.sv
module jseq_walker
    import jseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  realign,
    input  logic  advance,
    output tag_t  tag_raw
);
    logic [TYPE_W-1:0] slot;
    logic [RUN_W-1:0]  run;
    ctype_t            cur;
    logic              run_end;
    logic              slot_end;

    assign cur      = cfg.order[slot];
    assign run_end  = run >= final_run_idx(cfg.run[cur]);
    assign slot_end = slot >= cfg.last_slot;

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            slot <= '0;
            run  <= '0;
        end else if (advance) begin
            if (run_end) begin
                run  <= '0;
                slot <= slot_end ? '0 : slot + 1'b1;
            end else begin
                run  <= run + 1'b1;
            end
        end
    end

    always_comb begin
        tag_raw.valid = 1'b1;
        tag_raw.ctype = cur;
        tag_raw.huff  = cfg.huff[cur];
        tag_raw.qtab  = cfg.qtab[cur];
    end

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        advance && !realign && run_end && slot_end |=> slot == '0 && run == '0);

    // R8
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        realign |=> slot == '0 && run == '0);

    // R5
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        advance && !realign && !run_end |=> run == $past(run) + 1'b1 && $stable(slot));
endmodule

// File: rtl/jseq_block_sequencer.sv
module jseq_block_sequencer
    import jseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    input  logic                blk_done,
    input  logic                rst_mark,
    output logic                tag_valid,
    output logic [TYPE_W-1:0]   tag_type,
    output logic                tag_huff,
    output logic [1:0]          tag_qtab,
    output logic [CNT_W-1:0]    blocks_left,
    output logic                done
);
    cfg_t             cfg;
    tag_t             tag_raw;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             rst_take;
    logic             advance;
    logic             zero;

    assign rst_take = rst_mark && cfg.rst_en;
    assign advance  = blk_done && !zero && !rst_take && !load;

    jseq_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .load(load), .load_val(load_val)
    );

    jseq_counter u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .reload(rst_take), .dec(advance), .count(blocks_left), .zero(zero)
    );

    jseq_walker u_walk (
        .clk(clk), .rst(rst), .cfg(cfg), .realign(load || rst_take),
        .advance(advance), .tag_raw(tag_raw)
    );

    assign done      = zero;
    assign tag_valid = tag_raw.valid && !zero;
    assign tag_type  = tag_raw.ctype;
    assign tag_huff  = tag_raw.huff;
    assign tag_qtab  = tag_raw.qtab;

    // R9
    rst_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        rst_mark && !cfg.rst_en && !blk_done && !load |=> $stable(blocks_left));

    // R10
    frozen_tag_chk: assert property (@(posedge clk) disable iff (rst)
        done && blk_done && !rst_mark && !cfg_we |=> $stable(tag_type) && done);
endmodule

// File: tb/jseq_block_sequencer_tb_top.sv
module jseq_block_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        blk_done;
    logic        rst_mark;
    logic        tag_valid;
    logic [1:0]  tag_type;
    logic        tag_huff;
    logic [1:0]  tag_qtab;
    logic [23:0] blocks_left;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    jseq_block_sequencer dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .blk_done(blk_done), .rst_mark(rst_mark),
        .tag_valid(tag_valid), .tag_type(tag_type), .tag_huff(tag_huff),
        .tag_qtab(tag_qtab), .blocks_left(blocks_left), .done(done)
    );

    // Pattern: slots 1,3,0 with runs type1=2, type3=1, type0=0 (acts as 1)
    function automatic logic [1:0] exp_type(input int idx);
        case (idx % 4)
            0, 1: return 2'd1;
            2:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
    function automatic logic exp_huff(input logic [1:0] t);
        logic [3:0] h = 4'b1010;
        return h[t];
    endfunction
    function automatic logic [1:0] exp_q(input logic [1:0] t);
        logic [7:0] q = 8'hC6;
        return q[2*t +: 2];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic b, input logic r);
        @(negedge clk);
        blk_done = b; rst_mark = r;
        @(negedge clk);
        blk_done = 1'b0; rst_mark = 1'b0;
    endtask

    task automatic chk_tag(input string req, input int idx, input logic [23:0] left);
        logic [1:0] t = exp_type(idx);
        chk(req, {31'd0, tag_valid}, 32'd1);
        chk(req, {30'd0, tag_type}, {30'd0, t});
        chk({req, "/R7"}, {31'd0, tag_huff}, {31'd0, exp_huff(t)});
        chk({req, "/R7"}, {30'd0, tag_qtab}, {30'd0, exp_q(t)});
        chk({req, "/R3"}, {8'd0, blocks_left}, {8'd0, left});
    endtask

    task automatic t_reset;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; blk_done = 0; rst_mark = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd1);
        chk("R1 valid", {31'd0, tag_valid}, 32'd0);
        chk("R1 left", {8'd0, blocks_left}, 32'd0);
    endtask

    task automatic t_byte_order;
        wr(4'd8, 8'h01); wr(4'd8, 8'h02);
        chk("R2 partial", {8'd0, blocks_left}, 32'd0);
        wr(4'd8, 8'h03);
        chk("R2 value", {8'd0, blocks_left}, 32'h010203);
        chk("R2 valid", {31'd0, tag_valid}, 32'd1);
    endtask

    task automatic t_walk;
        wr(4'd0, 8'h02);
        wr(4'd1, 8'h8D);
        wr(4'd2, 8'h0A);
        wr(4'd3, 8'hC6);
        wr(4'd4, 8'd0); wr(4'd5, 8'd2); wr(4'd6, 8'd5); wr(4'd7, 8'd1);
        wr(4'd8, 8'h00); wr(4'd8, 8'h00); wr(4'd8, 8'h06);
        for (int i = 0; i < 6; i++) begin
            chk_tag("R4/R5/R6 walk", i, 24'(6 - i));
            pulse(1'b1, 1'b0);
        end
        chk("R10 done", {31'd0, done}, 32'd1);
        chk("R10 valid", {31'd0, tag_valid}, 32'd0);
        pulse(1'b1, 1'b0);
        chk("R10 hold", {8'd0, blocks_left}, 32'd0);
        chk("R10 tag frozen", {30'd0, tag_type}, {30'd0, exp_type(6)});
    endtask

    task automatic t_restart_on;
        wr(4'd0, 8'h06);
        pulse(1'b0, 1'b1);
        chk_tag("R8 reload", 0, 24'd6);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        chk_tag("R8 pre", 3, 24'd3);
        pulse(1'b1, 1'b1);
        chk_tag("R8 priority", 0, 24'd6);
    endtask

    task automatic t_restart_off;
        wr(4'd0, 8'h02);
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
        chk_tag("R9 pre", 2, 24'd4);
        pulse(1'b0, 1'b1);
        chk_tag("R9 ignored", 2, 24'd4);
    endtask

    task automatic t_single;
        wr(4'd0, 8'h00);
        wr(4'd8, 8'h00); wr(4'd8, 8'h00); wr(4'd8, 8'h04);
        for (int i = 0; i < 4; i++) begin
            chk("R6 single type", {30'd0, tag_type}, 32'd1);
            chk("R3 single left", {8'd0, blocks_left}, 32'(4 - i));
            pulse(1'b1, 1'b0);
        end
        chk("R10 single done", {31'd0, done}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_byte_order();
        t_walk();
        t_restart_on();
        t_restart_off();
        t_single();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule